// File: doc/BRIEF.md
# Four-Beat Burst Offset Sequencer

This block produces the low-order word offset for each beat of a short memory burst. When either of two independent address strobes is seen high on a rising clock edge, the block captures a starting offset. From then on it supplies every later offset of the burst by itself, stepping one position on each edge where the advance input is high and holding its position otherwise. The group has four words by default, so the offset wraps inside that group. After the fourth beat, a further step brings the offset back to the start.

A static order-select input picks how positions follow one another. In interleaved order, beat k sits at the start offset XOR k. In linear order, beat k sits at (start + k) modulo the group size. A flag marks the last beat of the group. The upper address bits, the storage array and the data path belong to the surrounding memory and are not part of this block.

Control is a two-state machine. ST_IDLE is entered at reset, and no burst is loaded in it. ST_BURST means a start offset is held. The transitions are:
- T_LOAD: ST_IDLE to ST_BURST, taken on any strobe.
- T_RELOAD: ST_BURST to ST_BURST, taken on any strobe. It restarts the burst.
- T_STEP: ST_BURST to ST_BURST, taken when advance is high and no strobe is present.
- T_HOLD: the state stays as it is, taken when there is neither a strobe nor an advance.

Top module: `burst_seq`

## Requirements
- R1: After reset, `ofs_out` is 0, `last_beat` is 0 and the block is idle.
- R2: A high `cpu_strobe` or `ctl_strobe` at a rising edge captures `start_ofs`. From the following edge, `ofs_out` equals that start and `last_beat` is 0, in either order.
- R3: While a burst is loaded, a high `adv` with no strobe moves the beat index k up by one. With `adv` low and no strobe, `ofs_out` and `last_beat` keep their values.
- R4: With `order_sel` = 1 (interleaved), `ofs_out` = start XOR k. For start 1 the sequence is 1,0,3,2.
- R5: With `order_sel` = 0 (linear), `ofs_out` = (start + k) mod 4. For start 1 the sequence is 1,2,3,0.
- R6: A strobe in the same cycle as `adv` takes priority. The counter reloads and k becomes 0.
- R7: An advance after the fourth beat (k = 3) wraps k to 0, so `ofs_out` returns to the start offset.
- R8: `last_beat` is 1 exactly when a burst is loaded and three advances have happened since the load (k = 3).
- R9: Before the first strobe after reset, `adv` has no effect. `ofs_out` stays 0 and `last_beat` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_strobe | input | 1 | Processor-side address strobe; loads a new start |
| ctl_strobe | input | 1 | Controller-side address strobe; loads a new start |
| start_ofs | input | OFS_W | Start offset captured on a strobe |
| adv | input | 1 | Step to the next burst position |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| ofs_out | output | OFS_W | Current burst offset |
| last_beat | output | 1 | High on the final beat of the group |

## Verification
The bench builds the block with the default OFS_W of 2, which gives a four-word group. With this size, every start offset and every beat position, including the wrap from k = 3 back to 0, is reached many times in both orders within a few thousand cycles. Random strobes, advances and order changes also bring the strobe-with-advance collision and the reload in the middle of a burst well within reach. Directed runs fix the two start-1 sequences and the behaviour while idle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bseq_state_e;
endpackage

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        adv,
    output bseq_state_e state,
    output logic        beat_clr,
    output logic        beat_inc
);
    bseq_state_e nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (load) nxt = ST_BURST;   // T_LOAD
            ST_BURST: nxt = ST_BURST;             // T_RELOAD, T_STEP, T_HOLD
            default:  nxt = ST_IDLE;
        endcase
    end

    // Outputs: a strobe outranks an advance
    always_comb begin
        beat_clr = 1'b0;
        beat_inc = 1'b0;
        unique case (state)
            ST_IDLE: begin
                beat_clr = load;
            end
            ST_BURST: begin
                beat_clr = load;
                beat_inc = !load && adv;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bseq_beat_cnt.sv
module bseq_beat_cnt #(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [OFS_W-1:0] start_in,
    output logic [OFS_W-1:0] start_q,
    output logic [OFS_W-1:0] beat_q
);
    localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
        end else if (clr) begin
            start_q <= start_in;
            beat_q  <= '0;
        end else if (inc) begin
            beat_q  <= beat_q + ONE;   // wraps inside the group
        end
    end
endmodule

// File: rtl/bseq_map.sv
module bseq_map #(
    parameter int OFS_W = 2
) (
    input  logic             active,
    input  logic             order_sel,
    input  logic [OFS_W-1:0] start_q,
    input  logic [OFS_W-1:0] beat_q,
    output logic [OFS_W-1:0] ofs,
    output logic             last
);
    logic [OFS_W-1:0] ilv_ofs;
    logic [OFS_W-1:0] lin_ofs;

    genvar b;
    generate
        for (b = 0; b < OFS_W; b++) begin : g_ilv
            assign ilv_ofs[b] = start_q[b] ^ beat_q[b];
        end
    endgenerate

    assign lin_ofs = start_q + beat_q;

    always_comb begin
        if (!active)        ofs = '0;
        else if (order_sel) ofs = ilv_ofs;
        else                ofs = lin_ofs;
        last = active && (&beat_q);
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import bseq_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_strobe,
    input  logic             ctl_strobe,
    input  logic [OFS_W-1:0] start_ofs,
    input  logic             adv,
    input  logic             order_sel,
    output logic [OFS_W-1:0] ofs_out,
    output logic             last_beat
);
    bseq_state_e      state;
    logic             load;
    logic             beat_clr;
    logic             beat_inc;
    logic [OFS_W-1:0] start_q;
    logic [OFS_W-1:0] beat_q;

    assign load = cpu_strobe | ctl_strobe;

    bseq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .state    (state),
        .beat_clr (beat_clr),
        .beat_inc (beat_inc)
    );

    bseq_beat_cnt #(.OFS_W(OFS_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (beat_clr),
        .inc      (beat_inc),
        .start_in (start_ofs),
        .start_q  (start_q),
        .beat_q   (beat_q)
    );

    bseq_map #(.OFS_W(OFS_W)) u_map (
        .active    (state == ST_BURST),
        .order_sel (order_sel),
        .start_q   (start_q),
        .beat_q    (beat_q),
        .ofs       (ofs_out),
        .last      (last_beat)
    );
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int OFS_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_strobe,
    input logic             ctl_strobe,
    input logic [OFS_W-1:0] start_ofs,
    input logic             adv,
    input logic             order_sel,
    input logic [OFS_W-1:0] ofs_out,
    input logic             last_beat
);
    // Independent shadow of load state, start and beat index
    logic             s_loaded;
    logic [OFS_W-1:0] s_start;
    logic [OFS_W-1:0] s_k;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_loaded <= 1'b0;
            s_start  <= '0;
            s_k      <= '0;
        end else if (cpu_strobe || ctl_strobe) begin
            s_loaded <= 1'b1;
            s_start  <= start_ofs;
            s_k      <= '0;
        end else if (s_loaded && adv) begin
            s_k      <= s_k + OFS_W'(1);
        end
    end

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !s_loaded |-> (ofs_out == '0 && !last_beat));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strobe || ctl_strobe) |=> (ofs_out == $past(start_ofs) && !last_beat));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe && !ctl_strobe && !adv) |=> $stable(last_beat));

    assert_interleave_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_loaded && order_sel) |-> ofs_out == (s_start ^ s_k));

    assert_linear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_loaded && !order_sel) |-> ofs_out == OFS_W'(s_start + s_k));

    assert_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_strobe || ctl_strobe) && adv) |=> !last_beat);

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && adv && !cpu_strobe && !ctl_strobe) |=> !last_beat);

    assert_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat == (s_loaded && (&s_k)));
endmodule

bind burst_seq bseq_chk #(.OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_strobe (cpu_strobe),
    .ctl_strobe (ctl_strobe),
    .start_ofs  (start_ofs),
    .adv        (adv),
    .order_sel  (order_sel),
    .ofs_out    (ofs_out),
    .last_beat  (last_beat)
);

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_strobe = 1'b0;
    logic         ctl_strobe = 1'b0;
    logic [W-1:0] start_ofs = '0;
    logic         adv = 1'b0;
    logic         order_sel = 1'b0;
    logic [W-1:0] ofs_out;
    logic         last_beat;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic         m_loaded = 1'b0;
    logic [W-1:0] m_start = '0;
    logic [W-1:0] m_k = '0;

    always #2.5 clk = ~clk;

    burst_seq #(.OFS_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_strobe(cpu_strobe), .ctl_strobe(ctl_strobe),
        .start_ofs(start_ofs), .adv(adv), .order_sel(order_sel),
        .ofs_out(ofs_out), .last_beat(last_beat)
    );

    function automatic logic [W-1:0] exp_ofs(input logic ld, input logic md,
                                             input logic [W-1:0] st, input logic [W-1:0] k);
        if (!ld)     return '0;
        else if (md) return st ^ k;
        else         return W'(st + k);
    endfunction

    task automatic compare(input string tag);
        logic [W-1:0] eo;
        logic         el;
        eo = exp_ofs(m_loaded, order_sel, m_start, m_k);
        el = m_loaded && (&m_k);
        n_chk++;
        if (ofs_out !== eo || last_beat !== el) begin
            n_bad++;
            $display("FAIL %s: ofs=%0d exp=%0d last=%0d exp=%0d",
                     tag, ofs_out, eo, last_beat, el);
        end
    endtask

    task automatic step(input logic c, input logic t, input logic [W-1:0] st,
                        input logic a, input logic md, input string tag);
        @(negedge clk);
        cpu_strobe = c; ctl_strobe = t; start_ofs = st; adv = a; order_sel = md;
        @(posedge clk);
        if (c || t) begin
            m_loaded = 1'b1; m_start = st; m_k = '0;
        end else if (m_loaded && a) begin
            m_k = m_k + 1'b1;
        end
        #1;
        compare(tag);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: ran=1 exp=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lin_seq [4];
        logic [W-1:0] ilv_seq [4];
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        compare("R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R9: advances before any load do nothing
        step(0, 0, 2'd3, 1, 1, "R9");
        step(0, 0, 2'd2, 1, 0, "R9");
        // R4: interleaved from start 1 via processor strobe
        ilv_seq = '{2'd1, 2'd0, 2'd3, 2'd2};
        step(1, 0, 2'd1, 0, 1, "R2");
        if (ofs_out !== ilv_seq[0]) begin n_bad++; $display("FAIL R4: ofs=%0d exp=%0d", ofs_out, ilv_seq[0]); end
        n_chk++;
        for (int i = 1; i < 4; i++) begin
            step(0, 0, 2'd0, 1, 1, (i == 3) ? "R8" : "R4");
            n_chk++;
            if (ofs_out !== ilv_seq[i]) begin n_bad++; $display("FAIL R4: ofs=%0d exp=%0d", ofs_out, ilv_seq[i]); end
        end
        step(0, 0, 2'd0, 0, 1, "R3");   // hold on last beat
        step(0, 0, 2'd0, 1, 1, "R7");   // wrap back to start
        // R5: linear from start 1 via controller strobe
        lin_seq = '{2'd1, 2'd2, 2'd3, 2'd0};
        step(0, 1, 2'd1, 0, 0, "R2");
        for (int i = 1; i < 4; i++) begin
            step(0, 0, 2'd2, 1, 0, "R5");
            n_chk++;
            if (ofs_out !== lin_seq[i]) begin n_bad++; $display("FAIL R5: ofs=%0d exp=%0d", ofs_out, lin_seq[i]); end
        end
        // R6: strobe together with advance reloads
        step(1, 1, 2'd2, 1, 0, "R6");
        step(0, 0, 2'd0, 0, 0, "R3");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic c, t, a, md;
            c  = ($urandom % 7) == 0;
            t  = ($urandom % 7) == 0;
            a  = ($urandom % 2) == 1;
            md = (i / 60) % 2 == 1;
            step(c, t, W'($urandom), a, md,
                 (c || t) ? ((a) ? "R6" : "R2") : (a ? (md ? "R4/R7/R8" : "R5/R7/R8") : "R3"));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule